// File: doc/BRIEF.md
# Wake Pin Trigger Detector

This block watches a set of external wake pins, one channel per pin, and reports when a pin meets the trigger condition chosen for its channel. Each pin first passes through a two-flop synchroniser. Each channel has a small configuration word. A 3-bit trigger code in that word selects one of six conditions: level low, level high, falling edge, rising edge, either edge, or no trigger. A level condition holds the channel's detect output high for as long as the level lasts. An edge condition gives a single-cycle detect pulse. The detect outputs go to a separate status and routing block, which is not part of this project.

The configuration word is written and read by channel index. Reading it also returns the live synchronised pin level. A per-channel hold bit silences the channel and clears its edge history, so that a pin change made while the channel was held does not appear as an edge on release. After reset every channel is set to the no-trigger code, so nothing fires until software has configured the channel.

Each channel runs a five-state sequencer that decides whether detection is allowed:
- FILL0, FILL1 and FILL2 step in turn after block reset while the synchroniser and the edge history fill.
- FILL2 moves to RUN. In RUN the detect output follows the trigger code.
- When the hold bit is set, every state moves to HOLD.
- When the hold bit is cleared, HOLD moves to FILL2, so that one extra cycle passes before RUN.

Top module: `wake_trig_top`

## Requirements
- R1: The configuration word of each channel has the following layout. Bit 0 reads the synchronised pin level and ignores writes. Bits [3:1] hold the trigger code. Bit 4 is the channel hold bit. All higher bits read as zero. A write with cfg_we high updates only the channel selected by cfg_sel. cfg_rdata shows the word of the channel selected by cfg_rsel.
- R2: After reset every channel holds trigger code 4 with the hold bit clear, and every detect output is low.
- R3: A pin change reaches the detect logic through two flops. A change applied before clock edge k shows on det_o after edge k+1.
- R4: Code 0 (level low) keeps det_o high for as long as the synchronised pin is low.
- R5: Code 1 (level high) keeps det_o high for as long as the synchronised pin is high.
- R6: Code 2 (falling) gives a one-cycle det_o pulse when the synchronised pin goes from 1 to 0, and nothing on a rise.
- R7: Code 3 (rising) gives a one-cycle det_o pulse when the synchronised pin goes from 0 to 1, and nothing on a fall.
- R8: Code 6 (either edge) gives a one-cycle det_o pulse on every transition of the synchronised pin.
- R9: Codes 4, 5 and 7 never assert det_o.
- R10: While the hold bit is set, det_o stays low from the second cycle after the write. After the bit is cleared, a pin change made during the hold gives no pulse, and detection works again.
- R11: Channels are independent. A write or pin activity on one channel does not change another channel's word or detect output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NCH | Asynchronous wake pins, one per channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Channel index for the write |
| cfg_wdata | input | DW | Write data |
| cfg_rsel | input | SEL_W | Channel index for the read |
| cfg_rdata | output | DW | Read data: the selected channel's configuration word |
| det_o | output | NCH | Detect output per channel, a level or a one-cycle pulse |

## Verification
The case that is hardest to reach from the ports is a pin that changes while its channel is held and then stays changed when the hold is released. If the edge history were not cleared, this case would give a stale edge. To produce it, the stimulus sets the hold bit on a channel in rising mode and toggles the pin during the hold. It checks that det_o stays low across the hold and for several cycles after release. It then makes a fresh rising edge to show that detection has resumed. A table of vectors covers every trigger code in both pin directions. Directed tests cover the reset word, the read-only pin bit and the separation between channels.

// File: rtl/wake_trig_pkg.sv
package wake_trig_pkg;
    localparam logic [2:0] TRG_LOW  = 3'd0;
    localparam logic [2:0] TRG_HIGH = 3'd1;
    localparam logic [2:0] TRG_FALL = 3'd2;
    localparam logic [2:0] TRG_RISE = 3'd3;
    localparam logic [2:0] TRG_OFF  = 3'd4;
    localparam logic [2:0] TRG_ANY  = 3'd6;

    localparam int PIN_BIT  = 0;
    localparam int CODE_LSB = 1;
    localparam int HOLD_BIT = 4;
    localparam int CFG_USED = 5;

    typedef enum logic [2:0] {
        CH_FILL0,
        CH_FILL1,
        CH_FILL2,
        CH_RUN,
        CH_HOLD
    } ch_state_t;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wake_chan.sv
module wake_chan
    import wake_trig_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] word_o,
    output logic          det_o
);
    logic      pin_s;
    logic      pin_prev;
    logic [2:0] code_q;
    logic      hold_q;
    ch_state_t state_q, state_d;

    wake_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= TRG_OFF;
            hold_q <= 1'b0;
        end else if (we_i) begin
            code_q <= wdata_i[CODE_LSB +: 3];
            hold_q <= wdata_i[HOLD_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_prev <= 1'b0;
        else        pin_prev <= pin_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_FILL0;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_FILL0: state_d = CH_FILL1;
            CH_FILL1: state_d = CH_FILL2;
            CH_FILL2: state_d = CH_RUN;
            CH_RUN:   state_d = CH_RUN;
            CH_HOLD:  state_d = CH_FILL2;
            default:  state_d = CH_FILL0;
        endcase
        if (hold_q) state_d = CH_HOLD;
    end

    always_comb begin
        det_o = 1'b0;
        if (state_q == CH_RUN) begin
            unique case (code_q)
                TRG_LOW:  det_o = !pin_s;
                TRG_HIGH: det_o = pin_s;
                TRG_FALL: det_o = pin_prev && !pin_s;
                TRG_RISE: det_o = !pin_prev && pin_s;
                TRG_ANY:  det_o = pin_prev != pin_s;
                default:  det_o = 1'b0;
            endcase
        end
    end

    always_comb begin
        word_o = '0;
        word_o[PIN_BIT]          = pin_s;
        word_o[CODE_LSB +: 3]    = code_q;
        word_o[HOLD_BIT]         = hold_q;
    end

    assert_rise_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (det_o && code_q == TRG_RISE) |=> !(det_o && code_q == TRG_RISE));

    assert_fall_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (det_o && code_q == TRG_FALL) |-> (!pin_s && $past(pin_s)));

    assert_off_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == 3'd4 || code_q == 3'd5 || code_q == 3'd7) |-> !det_o);

    assert_hold_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && $past(hold_q)) |-> !det_o);
endmodule

// File: rtl/wake_trig_top.sv
module wake_trig_top
    import wake_trig_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int DW    = 32,
    parameter int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   pin_i,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [DW-1:0]    cfg_wdata,
    input  logic [SEL_W-1:0] cfg_rsel,
    output logic [DW-1:0]    cfg_rdata,
    output logic [NCH-1:0]   det_o
);
    logic [DW-1:0] word_w [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic we_g;
        assign we_g = cfg_we && (cfg_sel == SEL_W'(g));
        wake_chan #(.DW(DW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pin_i[g]),
            .we_i    (we_g),
            .wdata_i (cfg_wdata),
            .word_o  (word_w[g]),
            .det_o   (det_o[g])
        );
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NCH; i++)
            if (cfg_rsel == SEL_W'(i)) cfg_rdata = word_w[i];
    end

    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[DW-1:CFG_USED] == '0);
endmodule

// File: tb/test_wake_trig_top.sv
`timescale 1ns/1ps
module test_wake_trig_top;
    localparam int NCH = 4;
    localparam int DW  = 32;
    localparam int SW  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] pin_i = '0;
    logic cfg_we = 1'b0;
    logic [SW-1:0] cfg_sel = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [SW-1:0] cfg_rsel = '0;
    logic [DW-1:0] cfg_rdata;
    logic [NCH-1:0] det_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wake_trig_top #(.NCH(NCH), .DW(DW)) i_wake_trig_top (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel),
        .cfg_rdata(cfg_rdata), .det_o(det_o)
    );

    // {code[6:4], pin_before[3], pin_after[2], det_after2[1], det_after3[0]}
    localparam logic [6:0] VEC [13] = '{
        {3'd0, 1'b1, 1'b0, 1'b1, 1'b1},  // R4
        {3'd0, 1'b0, 1'b1, 1'b0, 1'b0},  // R4
        {3'd1, 1'b0, 1'b1, 1'b1, 1'b1},  // R5
        {3'd1, 1'b1, 1'b0, 1'b0, 1'b0},  // R5
        {3'd2, 1'b1, 1'b0, 1'b1, 1'b0},  // R6
        {3'd2, 1'b0, 1'b1, 1'b0, 1'b0},  // R6
        {3'd3, 1'b0, 1'b1, 1'b1, 1'b0},  // R7
        {3'd3, 1'b1, 1'b0, 1'b0, 1'b0},  // R7
        {3'd6, 1'b0, 1'b1, 1'b1, 1'b0},  // R8
        {3'd6, 1'b1, 1'b0, 1'b1, 1'b0},  // R8
        {3'd4, 1'b0, 1'b1, 1'b0, 1'b0},  // R9
        {3'd5, 1'b0, 1'b1, 1'b0, 1'b0},  // R9
        {3'd7, 1'b1, 1'b0, 1'b0, 1'b0}   // R9
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input logic [DW-1:0] d);
        cfg_we = 1'b1;
        cfg_sel = SW'(ch);
        cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int ch, output logic [DW-1:0] d);
        cfg_rsel = SW'(ch);
        #0.5;
        d = cfg_rdata;
    endtask

    initial begin
        logic [DW-1:0] w;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R2 reset word: code 4 in [3:1], hold clear, pin 0 -> 0x8
        for (int c = 0; c < NCH; c++) begin
            rd(c, w);
            chk("R2 reset word", w, 32'h8);
        end
        chk("R2 reset det", 32'(det_o), 32'h0);
        repeat (3) tick();

        // table of trigger codes on channel 0
        for (int v = 0; v < 13; v++) begin
            wr(0, {28'd0, VEC[v][6:4], 1'b0});
            pin_i[0] = VEC[v][3];
            repeat (4) tick();
            pin_i[0] = VEC[v][2];
            tick();
            tick();
            chk("R3-latency/code det after 2 edges", 32'(det_o[0]), 32'(VEC[v][1]));
            tick();
            chk("R4..R9 code det after 3 edges", 32'(det_o[0]), 32'(VEC[v][0]));
        end

        // R3: nothing after one edge
        wr(0, {28'd0, 3'd1, 1'b0});
        pin_i[0] = 1'b0;
        repeat (4) tick();
        pin_i[0] = 1'b1;
        tick();
        chk("R3 not yet after one edge", 32'(det_o[0]), 32'h0);
        tick();
        chk("R3 level seen after two edges", 32'(det_o[0]), 32'h1);

        // R1: pin bit read-only, tracks pin; bit 0 write ignored
        pin_i[1] = 1'b0;
        wr(1, 32'hFFFF_FFE7);  // code 3, hold 0, bit0 = 1, upper ones
        tick();
        rd(1, w);
        chk("R1 write bit0 ignored, upper zero", w, 32'h6);
        pin_i[1] = 1'b1;
        tick(); tick();
        rd(1, w);
        chk("R1 pin bit reads live level", w, 32'h7);

        // R11: channel 0 word untouched by channel 1 write
        rd(0, w);
        chk("R11 other channel word kept", w, 32'h3);
        rd(2, w);
        chk("R11 untouched channel word", w, 32'h8);

        // R11: simultaneous channels, ch2 rising, ch3 falling
        wr(2, {28'd0, 3'd3, 1'b0});
        wr(3, {28'd0, 3'd2, 1'b0});
        pin_i[2] = 1'b0; pin_i[3] = 1'b0;
        repeat (4) tick();
        pin_i[2] = 1'b1; pin_i[3] = 1'b1;
        tick(); tick();
        chk("R11 rise on ch2 only", 32'(det_o[3:2]), 32'h1);
        pin_i[2] = 1'b0; pin_i[3] = 1'b0;
        tick(); tick();
        chk("R11 fall on ch3 only", 32'(det_o[3:2]), 32'h2);

        // R10: hold during a pin change
        pin_i[0] = 1'b0;
        wr(0, {28'd0, 3'd3, 1'b0});
        repeat (4) tick();
        wr(0, {27'd0, 1'b1, 3'd3, 1'b0});
        tick();
        rd(0, w);
        chk("R10 hold bit reads back", w & 32'h1E, 32'h16);
        pin_i[0] = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R10 silent during hold", 32'(det_o[0]), 32'h0);
        end
        wr(0, {28'd0, 3'd3, 1'b0});
        for (int k = 0; k < 4; k++) begin
            chk("R10 no stale edge on release", 32'(det_o[0]), 32'h0);
            tick();
        end
        pin_i[0] = 1'b0;
        repeat (3) tick();
        pin_i[0] = 1'b1;
        tick(); tick();
        chk("R10 detection resumes", 32'(det_o[0]), 32'h1);

        // R10: level high held silent
        wr(0, {27'd0, 1'b1, 3'd1, 1'b0});
        tick();
        chk("R10 level mode silent in hold", 32'(det_o[0]), 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule